// File: doc/BRIEF.md
# Byte-Wide Host Read Port

This block is the slave side of a parallel host port. It lets an external processor fetch a 16-bit word, posted by the local core, as two bytes over an 8-bit bus. The host uses four control pins: an active-low chip select, a read/not-write line, a data strobe and a byte-select line. The port drives the byte bus only while a read access is open and releases it otherwise. The byte bus leaves the block as a data vector and an output-enable, so the pad ring can build the tri-state driver.

The host pins arrive asynchronously. Each one passes through a two-flop synchronizer, and all decoding is done in the block clock domain. A small configuration register can invert the active sense of the strobe and of the byte-select input. The core loads a new word through a single-cycle load port, and this load clears the empty flag. When the host finishes a high-byte read, the block pulses an interrupt for one clock and sets the empty level, which then stays high until the next load.

Top module: `host_rd_port`

## Requirements
- R1: After reset `bus_oe_o` is 0, `obe_irq_o` is 0, `obe_o` is 1, both polarity bits are 0, and the held word is 0.
- R2: The bus is driven (`bus_oe_o`=1) only while chip select is low, the strobe is at its active level and `rw_i` is 1. With `rw_i`=0 the bus is never driven, and no interrupt or change of `obe_o` follows.
- R3: When byte-select is at its low-byte level, `bus_o` carries bits [7:0] of the held word. At its high-byte level, `bus_o` carries bits [15:8]. With bit 1 of the configuration at 0, the low-byte level is 0.
- R4: The bus is released when either chip select goes high or the strobe leaves its active level, whichever happens first.
- R5: Configuration bit 0, written through `cfg_we_i`/`cfg_wdata_i`, makes the strobe active-high when it is 1 (active-low when 0). Configuration bit 1 makes byte-select level 1 pick the low byte when it is 1.
- R6: When a read access whose last selected byte was the high byte ends, `obe_irq_o` is high for exactly one clock and `obe_o` goes to 1.
- R7: Ending a low-byte read changes neither `obe_o` nor `obe_irq_o`. Repeated low-byte reads return the same byte.
- R8: `load_i` replaces the held word with `load_data_i` and clears `obe_o` on the next clock. After that, `obe_o` stays 0 until a high-byte read completes, and once set it stays 1 until the next load.
- R9: A change on a host pin reaches `bus_oe_o` after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the polarity configuration |
| cfg_wdata_i | input | 2 | Bit 0 inverts the strobe, bit 1 inverts byte-select |
| load_i | input | 1 | Core loads a new output word |
| load_data_i | input | 16 | Word to be read by the host |
| cs_ni | input | 1 | Host chip select, active low |
| rw_i | input | 1 | Host read (1) / write (0) |
| strb_i | input | 1 | Host data strobe, polarity programmable |
| bsel_i | input | 1 | Host byte select, polarity programmable |
| bus_o | output | 8 | Byte presented to the host |
| bus_oe_o | output | 1 | Enable for the byte bus driver |
| obe_o | output | 1 | Output buffer empty level |
| obe_irq_o | output | 1 | One-clock pulse when the high byte has been taken |

## Verification
The bench runs random two-byte transfers in which the polarity settings, the number of extra low-byte reads and the pin released first are all drawn at random. It also runs a directed write-direction access and a check of the synchronizer latency.

- A port that counted any access end as completion would pulse on low-byte reads.
- A port that ignored `rw_i` would drive the bus during a host write.
- A port that waited for both chip select and strobe to release would keep `bus_oe_o` high after only one of them rose.
- Inverting the wrong polarity bit would return the other byte, or no byte, once the configuration changes.

// File: rtl/host_rd_pkg.sv
package host_rd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic cs_n;
    logic rw;
    logic strb;
    logic bsel;
  } host_ctl_t;

  localparam int unsigned CTL_W = $bits(host_ctl_t);

  typedef struct packed {
    logic bsel_inv;
    logic strb_inv;
  } host_cfg_t;
endpackage

// File: rtl/host_rd_sync.sv
module host_rd_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/host_rd_decode.sv
module host_rd_decode
  import host_rd_pkg::*;
(
  input  host_ctl_t ctl_i,
  input  host_cfg_t cfg_i,
  output logic      access_o,
  output logic      hi_sel_o
);
  logic strb_act;

  // strobe idles high unless inverted
  assign strb_act = ctl_i.strb ^ ~cfg_i.strb_inv;
  assign hi_sel_o = ctl_i.bsel ^ cfg_i.bsel_inv;
  assign access_o = ~ctl_i.cs_n & strb_act & ctl_i.rw;
endmodule

// File: rtl/host_rd_flag.sv
module host_rd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic hi_sel_i,
  input  logic load_i,
  output logic obe_o,
  output logic irq_o
);
  logic access_q, hi_q, irq_q, obe_q, end_hi;

  assign end_hi = access_q & ~access_i & hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      access_q <= 1'b0;
      hi_q     <= 1'b0;
      irq_q    <= 1'b0;
      obe_q    <= 1'b1;
    end else begin
      access_q <= access_i;
      if (access_i) hi_q <= hi_sel_i;
      irq_q <= end_hi;
      // a fresh load wins over a completing read
      if (load_i)      obe_q <= 1'b0;
      else if (end_hi) obe_q <= 1'b1;
    end
  end

  assign obe_o = obe_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/host_rd_port.sv
module host_rd_port
  import host_rd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_wdata_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              strb_i,
  input  logic              bsel_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              obe_o,
  output logic              obe_irq_o
);
  host_cfg_t         cfg_q;
  logic [WORD_W-1:0] word_q;
  host_ctl_t         ctl_raw, ctl_s;
  logic              access, hi_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      word_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= host_cfg_t'(cfg_wdata_i);
      if (load_i)   word_q <= load_data_i;
    end
  end

  assign ctl_raw = '{cs_n: cs_ni, rw: rw_i, strb: strb_i, bsel: bsel_i};

  // idle: deselected, read, strobe high, low byte
  host_rd_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_W'(4'b1110))
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  host_rd_decode u_dec (
    .ctl_i   (ctl_s),
    .cfg_i   (cfg_q),
    .access_o(access),
    .hi_sel_o(hi_sel)
  );

  host_rd_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .access_i(access),
    .hi_sel_i(hi_sel),
    .load_i  (load_i),
    .obe_o   (obe_o),
    .irq_o   (obe_irq_o)
  );

  assign bus_oe_o = access;
  assign bus_o    = hi_sel ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
endmodule

// File: rtl/host_rd_port_chk.sv
module host_rd_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic rw_i,
  input logic bus_oe_o,
  input logic obe_o,
  input logic obe_irq_o
);
  AST_IRQ_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obe_irq_o |=> !obe_irq_o); // R6

  AST_IRQ_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obe_irq_o && !$past(load_i)) |-> obe_o); // R6

  AST_EMPTY_ONLY_BY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obe_o) |-> obe_irq_o); // R7

  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !obe_o); // R8

  AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obe_o && !load_i) |=> obe_o); // R8

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_i && $past(!rw_i) && $past(!rw_i, 2)) |-> !bus_oe_o); // R2
endmodule

bind host_rd_port host_rd_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .rw_i     (rw_i),
  .bus_oe_o (bus_oe_o),
  .obe_o    (obe_o),
  .obe_irq_o(obe_irq_o)
);

// File: tb/tb_host_rd_port.sv
`timescale 1ns/1ps
module tb_host_rd_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_wdata_i = 2'b00;
  logic        load_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic        cs_ni = 1'b1, rw_i = 1'b1, strb_i = 1'b1, bsel_i = 1'b0;
  logic [7:0]  bus_o;
  logic        bus_oe_o, obe_o, obe_irq_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] word_m = '0;
  bit obe_m = 1'b1, sinv_m = 1'b0, binv_m = 1'b0;

  always #10 clk_i = ~clk_i;

  host_rd_port dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit hi);
    return hi ? word_m[15:8] : word_m[7:0];
  endfunction

  task automatic idle_pins();
    cs_ni = 1'b1; strb_i = sinv_m ? 1'b0 : 1'b1; rw_i = 1'b1;
  endtask

  task automatic set_cfg(input bit s, input bit b);
    @(negedge clk_i);
    cs_ni = 1'b1;
    cfg_we_i = 1'b1; cfg_wdata_i = {b, s};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    sinv_m = s; binv_m = b;
    idle_pins();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk_i);
    load_i = 1'b1; load_data_i = w;
    @(negedge clk_i);
    load_i = 1'b0;
    word_m = w; obe_m = 1'b0;
    chk(obe_o == 1'b0, "R8", "obe after load", 16'(obe_o), 16'(0));
  endtask

  // one host byte read; cs_first picks which pin releases first
  task automatic rd(input bit hi, input bit cs_first, input bit chk_lat);
    int irqs;
    @(negedge clk_i);
    rw_i = 1'b1; bsel_i = hi ^ binv_m; cs_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    strb_i = sinv_m ? 1'b1 : 1'b0;
    @(negedge clk_i);
    if (chk_lat) chk(bus_oe_o == 1'b0, "R9", "oe after one edge", 16'(bus_oe_o), 16'(0));
    @(negedge clk_i);
    chk(bus_oe_o == 1'b1, chk_lat ? "R9" : "R2", "oe during read", 16'(bus_oe_o), 16'(1));
    chk(bus_o == exp_byte(hi), hi ? "R3 hi" : "R3 lo", sinv_m|binv_m ? "byte R5" : "byte",
        16'(bus_o), 16'(exp_byte(hi)));
    if (cs_first) cs_ni = 1'b1; else strb_i = sinv_m ? 1'b0 : 1'b1;
    irqs = 0;
    repeat (6) begin @(negedge clk_i); irqs += int'(obe_irq_o); end
    chk(bus_oe_o == 1'b0, "R4", cs_first ? "release by cs" : "release by strobe",
        16'(bus_oe_o), 16'(0));
    idle_pins();
    repeat (3) begin @(negedge clk_i); irqs += int'(obe_irq_o); end
    if (hi) begin
      obe_m = 1'b1;
      chk(irqs == 1, "R6", "irq pulses", 16'(irqs), 16'(1));
    end else begin
      chk(irqs == 0, "R7", "irq on low read", 16'(irqs), 16'(0));
    end
    chk(obe_o == obe_m, hi ? "R6" : "R7", "obe level", 16'(obe_o), 16'(obe_m));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(bus_oe_o == 1'b0, "R1", "oe reset", 16'(bus_oe_o), 16'(0));
    chk(obe_o == 1'b1, "R1", "obe reset", 16'(obe_o), 16'(1));
    chk(obe_irq_o == 1'b0, "R1", "irq reset", 16'(obe_irq_o), 16'(0));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(1'b0, 1'b0, 1'b1);  // R1 word reads 0, R7 low read keeps obe
    chk(bus_o == 8'h00, "R1", "reset word", 16'(bus_o), 16'(0));

    load(16'hA55A);
    rd(1'b0, 1'b0, 1'b1);
    rd(1'b0, 1'b1, 1'b0);  // R7 repeated low read
    rd(1'b1, 1'b1, 1'b0);
    // R8 obe stays high without load
    repeat (5) @(negedge clk_i);
    chk(obe_o == 1'b1, "R8", "obe holds", 16'(obe_o), 16'(1));

    // R2 write direction: no drive, no irq, obe unchanged
    load(16'h1234);
    begin
      int irqs = 0, oes = 0;
      @(negedge clk_i);
      rw_i = 1'b0; bsel_i = 1'b1; cs_ni = 1'b0; strb_i = 1'b0;
      repeat (6) begin @(negedge clk_i); oes += int'(bus_oe_o); end
      idle_pins();
      repeat (6) begin @(negedge clk_i); irqs += int'(obe_irq_o); end
      chk(oes == 0, "R2", "oe on write", 16'(oes), 16'(0));
      chk(irqs == 0 && obe_o == 1'b0, "R2", "irq/obe on write",
          16'({irqs[7:0], 7'd0, obe_o}), 16'(0));
    end

    // R5 directed: both polarities inverted
    set_cfg(1'b1, 1'b1);
    rd(1'b0, 1'b0, 1'b0);
    rd(1'b1, 1'b0, 1'b0);

    // random transfers
    for (int t = 0; t < 60; t++) begin
      set_cfg(1'($urandom), 1'($urandom));
      load(16'($urandom));
      for (int k = 0; k < int'($urandom_range(0, 2)); k++)
        rd(1'b0, 1'($urandom), 1'b0);
      rd(1'b1, 1'($urandom), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule